// File: doc/BRIEF.md
# Triggered Window Capture Controller

This block sits between a four-channel sample stream and a display frame memory. Each sample is one 48-bit word that packs four 12-bit channel readings, and it arrives with a valid strobe. After reset the controller fills a circular history with the most recent samples. Once the history is full, it keeps overwriting the oldest entry and waits for a trigger. The trigger counts only when an internal trigger-condition pulse arrives while a pushbutton press has been recorded.

After the trigger the controller records a fixed run of later samples. It then copies the whole window into a 640-entry frame memory through a plain write port. The history goes first, from oldest to newest, and the later samples follow in arrival order. It then sends a one-cycle done strobe to the display stage and starts a fresh capture. Input samples that arrive while the memory is being written are dropped. The block does not detect trigger conditions; the condition pulse comes from another block.

Top module: `snap_capture`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `state_code` is 0, `mem_we` is 0 and `done_pulse` is 0.
- R2: In state 0 (fill), each valid sample goes into the history. After the 320th valid sample the state becomes 1 (wait) on that same clock edge. A trigger-condition pulse seen in state 0 is ignored.
- R3: In state 1 the history keeps taking valid samples and holds the newest 320. A sample that is valid in the cycle the trigger is taken belongs to the history.
- R4: The key input passes through a two-flop synchroniser, and only its rising edge is used. A rising edge seen in state 0 or 1 is remembered. The trigger is taken in state 1 when `trig_cond` is high and a remembered edge exists; the next state is then 2 (post). `trig_cond` with no remembered edge leaves the block in state 1.
- R5: In state 2 the next 320 valid samples are recorded in arrival order. Cycles where valid is low do not advance the count.
- R6: Once the 320th post sample is taken, state 3 writes the history to addresses 0 to 319, one write per cycle with no gaps. Address 0 holds the oldest sample and address 319 holds the newest.
- R7: State 4 follows at once and writes the post samples to addresses 320 to 639 in arrival order, one per cycle.
- R8: `done_pulse` is high for exactly one cycle, in state 5, which is the cycle after the write to address 639. The state then returns to 0 with an empty history.
- R9: Samples and trigger pulses that arrive in states 3, 4 or 5 are ignored. They never reach the frame memory and they do not count toward the next fill.
- R10: `state_code` encodes 0 fill, 1 wait, 2 post, 3 history write, 4 post write, 5 done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 48 | Four packed 12-bit channel readings |
| trig_cond | input | 1 | Internal trigger-condition pulse |
| key_raw | input | 1 | Unsynchronised pushbutton level |
| mem_we | output | 1 | Frame memory write enable |
| mem_addr | output | 10 | Frame memory write address |
| mem_wdata | output | 48 | Frame memory write data |
| done_pulse | output | 1 | One-cycle new-frame strobe to the display stage |
| state_code | output | 3 | Current phase, encoded as in R10 |

## Verification
Two actions can land in the same clock edge: taking the trigger, and writing a valid sample into the history. The bench raises `trig_cond` together with a valid sample, after a key edge has been remembered. It then expects that sample at address 319 and the first sample after it at address 320. A second collision happens on the edge that stores the 320th fill sample, when a condition pulse arrives in that cycle or in the fill state. The bench judges this from the state code, which must stay at 0 or move only to 1. Junk samples and condition pulses are applied during every write-out, and the fill of the next capture must still start at the first real sample.

// File: rtl/snap_pkg.sv
`timescale 1ns/1ps
package snap_pkg;
  typedef enum logic [2:0] {
    ST_FILL      = 3'd0,
    ST_WAIT      = 3'd1,
    ST_POST      = 3'd2,
    ST_DUMP_PRE  = 3'd3,
    ST_DUMP_POST = 3'd4,
    ST_DONE      = 3'd5
  } snap_state_e;
endpackage

// File: rtl/key_edge.sv
`timescale 1ns/1ps
// Synchroniser chain followed by a rising-edge detector.
module key_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_raw,
  output logic key_rise
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], key_raw};
  end

  assign key_rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/ring_store.sv
`timescale 1ns/1ps
// Circular history: the write pointer always marks the oldest entry once full.
module ring_store #(
  parameter int W     = 48,
  parameter int DEPTH = 320,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic [PW-1:0] rd_off,
  output logic [W-1:0]  rd_data
);
  localparam logic [PW-1:0] LAST    = PW'(DEPTH - 1);
  localparam logic [PW:0]   DEPTH_L = (PW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr_q;
  logic [PW:0]   sum;
  logic [PW:0]   idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (clr)   ptr_q <= '0;
    else if (wr_en) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[ptr_q] <= wr_data;
  end

  always_comb begin
    sum = {1'b0, ptr_q} + {1'b0, rd_off};
    idx = (sum >= DEPTH_L) ? sum - DEPTH_L : sum;
  end

  assign rd_data = mem[idx[PW-1:0]];
endmodule

// File: rtl/line_store.sv
`timescale 1ns/1ps
// Linear post-trigger store, written and read by explicit index.
module line_store #(
  parameter int W     = 48,
  parameter int DEPTH = 320,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/snap_capture.sv
`timescale 1ns/1ps
module snap_capture #(
  parameter int SAMPLE_W   = 48,
  parameter int SEG        = 320,
  parameter int KEY_STAGES = 2,
  localparam int CNT_W     = $clog2(SEG),
  localparam int ADDR_W    = $clog2(2 * SEG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                trig_cond,
  input  logic                key_raw,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [SAMPLE_W-1:0] mem_wdata,
  output logic                done_pulse,
  output logic [2:0]          state_code
);
  import snap_pkg::*;

  localparam logic [CNT_W-1:0]  SEG_LAST = CNT_W'(SEG - 1);
  localparam logic [ADDR_W-1:0] POST_BASE = ADDR_W'(SEG);

  snap_state_e          state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 key_seen_q, key_seen_d;
  logic                 key_rise;
  logic                 fire;
  logic                 cnt_last;
  logic                 ring_we, line_we;
  logic [SAMPLE_W-1:0]  ring_rd, line_rd;

  key_edge #(.STAGES(KEY_STAGES)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_raw  (key_raw),
    .key_rise (key_rise)
  );

  assign ring_we = smp_valid && (state_q == ST_FILL || state_q == ST_WAIT);
  assign line_we = smp_valid && (state_q == ST_POST);

  ring_store #(.W(SAMPLE_W), .DEPTH(SEG)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state_q == ST_DONE),
    .wr_en   (ring_we),
    .wr_data (smp_data),
    .rd_off  (cnt_q),
    .rd_data (ring_rd)
  );

  line_store #(.W(SAMPLE_W), .DEPTH(SEG)) u_post (
    .clk     (clk),
    .wr_en   (line_we),
    .wr_idx  (cnt_q),
    .wr_data (smp_data),
    .rd_idx  (cnt_q),
    .rd_data (line_rd)
  );

  assign cnt_last = (cnt_q == SEG_LAST);
  assign fire     = (state_q == ST_WAIT) && trig_cond && key_seen_q;

  // Next-state and counter logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_FILL: begin
        if (smp_valid) begin
          if (cnt_last) begin
            state_d = ST_WAIT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (fire) begin
          state_d = ST_POST;
          cnt_d   = '0;
        end
      end
      ST_POST: begin
        if (smp_valid) begin
          if (cnt_last) begin
            state_d = ST_DUMP_PRE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DUMP_PRE: begin
        if (cnt_last) begin
          state_d = ST_DUMP_POST;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DUMP_POST: begin
        if (cnt_last) begin
          state_d = ST_DONE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE: begin
        state_d = ST_FILL;
        cnt_d   = '0;
      end
      default: begin
        state_d = ST_FILL;
        cnt_d   = '0;
      end
    endcase
  end

  // Remembered key edge: accepted only while filling or waiting
  always_comb begin
    key_seen_d = key_seen_q;
    if (fire || !(state_q == ST_FILL || state_q == ST_WAIT)) key_seen_d = 1'b0;
    else if (key_rise)                                        key_seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_FILL;
      cnt_q      <= '0;
      key_seen_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      key_seen_q <= key_seen_d;
    end
  end

  // Write port
  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (state_q == ST_DUMP_PRE) begin
      mem_we    = 1'b1;
      mem_addr  = ADDR_W'(cnt_q);
      mem_wdata = ring_rd;
    end else if (state_q == ST_DUMP_POST) begin
      mem_we    = 1'b1;
      mem_addr  = ADDR_W'(cnt_q) + POST_BASE;
      mem_wdata = line_rd;
    end
  end

  assign done_pulse = (state_q == ST_DONE);
  assign state_code = state_q;
endmodule

// File: rtl/snap_capture_chk.sv
`timescale 1ns/1ps
module snap_capture_chk #(
  parameter int ADDR_W = 10,
  parameter int SEG    = 320
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              trig_cond,
  input logic              key_seen,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done_pulse,
  input logic [2:0]        state_code
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(2 * SEG - 1);

  // R6
  first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_we)) |-> (mem_addr == '0));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> ($past(mem_we) && $past(mem_addr) == LAST_ADDR));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> (!done_pulse && state_code == 3'd0));

  // R4
  fire_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd2 && $past(state_code) == 3'd1) |-> ($past(trig_cond) && $past(key_seen)));

  // R2
  wait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd1 && $past(state_code) != 3'd1) |-> ($past(state_code) == 3'd0 && $past(smp_valid)));
endmodule

bind snap_capture snap_capture_chk #(.ADDR_W(ADDR_W), .SEG(SEG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .trig_cond  (trig_cond),
  .key_seen   (key_seen_q),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .done_pulse (done_pulse),
  .state_code (state_code)
);

// File: tb/snap_capture_test.sv
`timescale 1ns/1ps
module snap_capture_test;
  localparam int W   = 48;
  localparam int SEG = 320;
  localparam int AW  = $clog2(2 * SEG);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_valid;
  logic [W-1:0]  smp_data;
  logic          trig_cond;
  logic          key_raw;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  mem_wdata;
  logic          done_pulse;
  logic [2:0]    state_code;

  always #4 clk = ~clk;

  snap_capture uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .trig_cond  (trig_cond),
    .key_raw    (key_raw),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .done_pulse (done_pulse),
    .mem_wdata  (mem_wdata),
    .state_code (state_code)
  );

  typedef struct packed {
    logic [AW-1:0] a;
    logic [W-1:0]  d;
  } wr_t;

  wr_t          exp_q[$];
  logic [W-1:0] hist[$];
  wr_t          cur;
  int           checks    = 0;
  int           fails     = 0;
  int           done_cnt  = 0;
  int           wr_since  = 0;
  int           post_n    = 0;
  bit           prev_done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [W-1:0] mk(input int id, input int n);
    return {8'(id), 8'hA5, 32'(n)};
  endfunction

  // Inputs are set 1 ns after an edge and held through the next edge.
  task automatic step(input logic v, input logic [W-1:0] d, input logic t);
    smp_valid = v;
    smp_data  = d;
    trig_cond = t;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) step(1'b0, '0, 1'b0);
  endtask

  task automatic send_pre(input logic [W-1:0] d, input logic t);
    step(1'b1, d, t);
    hist.push_back(d);
    if (hist.size() > SEG) void'(hist.pop_front());
  endtask

  task automatic begin_post();
    for (int i = 0; i < SEG; i++) exp_q.push_back({AW'(i), hist[i]});
    hist.delete();
    post_n = 0;
  endtask

  task automatic send_post(input logic [W-1:0] d);
    exp_q.push_back({AW'(SEG + post_n), d});
    post_n++;
    step(1'b1, d, 1'b0);
  endtask

  // R9: junk samples and condition pulses during write-out
  task automatic drain();
    int prev;
    int j;
    prev = done_cnt;
    j = 0;
    while (done_cnt == prev) begin
      step(1'b1, 48'hBAD0_0000_0000 + 48'(j), (j % 7) == 0);
      j++;
    end
    smp_valid = 1'b0;
    trig_cond = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "write with nothing expected", 64'(mem_addr), 0);
        end else begin
          cur = exp_q.pop_front();
          if (cur.a < AW'(SEG)) begin
            chk(mem_addr == cur.a, "R6", "history address", 64'(mem_addr), 64'(cur.a));
            chk(mem_wdata == cur.d, "R3", "history data", 64'(mem_wdata), 64'(cur.d));
          end else begin
            chk(mem_addr == cur.a, "R7", "post address", 64'(mem_addr), 64'(cur.a));
            chk(mem_wdata == cur.d, "R5", "post data", 64'(mem_wdata), 64'(cur.d));
          end
          chk(mem_wdata[W-1:W-12] != 12'hBAD, "R9", "junk sample in memory",
              64'(mem_wdata), 64'(cur.d));
        end
        wr_since++;
      end
      if (prev_done)
        chk(state_code == 3'd0, "R8", "state after done", 64'(state_code), 0);
      if (done_pulse) begin
        chk(wr_since == 2 * SEG, "R8", "writes before done", 64'(wr_since), 64'(2 * SEG));
        chk(exp_q.size() == 0, "R8", "pending writes at done", 64'(exp_q.size()), 0);
        wr_since = 0;
        done_cnt++;
      end
      prev_done = done_pulse;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    smp_valid = 1'b0;
    smp_data  = '0;
    trig_cond = 1'b0;
    key_raw   = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(state_code == 3'd0, "R1", "state in reset", 64'(state_code), 0);
    chk(mem_we == 1'b0, "R1", "write enable in reset", 64'(mem_we), 0);
    chk(done_pulse == 1'b0, "R1", "done in reset", 64'(done_pulse), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(state_code == 3'd0 && !mem_we && !done_pulse, "R1", "after reset",
        64'({state_code, mem_we, done_pulse}), 0);

    // Capture 1: wrapped history, trigger together with a valid sample
    for (int n = 0; n < SEG; n++) send_pre(mk(1, n), 1'b0);
    chk(state_code == 3'd1, "R2", "wait after 320 samples (R10 code 1)", 64'(state_code), 1);
    idle(2);
    for (int n = SEG; n < 500; n++) begin
      send_pre(mk(1, n), 1'b0);
      if (n % 5 == 0) idle(1);
    end
    chk(state_code == 3'd1, "R3", "still waiting while history wraps", 64'(state_code), 1);
    key_raw = 1'b1;
    idle(6);
    send_pre(mk(1, 500), 1'b1);
    chk(state_code == 3'd2, "R4", "trigger taken with key (R10 code 2)", 64'(state_code), 2);
    begin_post();
    for (int i = 0; i < SEG; i++) begin
      send_post(mk(1, 1000 + i));
      if (i % 3 == 0 && i != SEG - 1) idle(1);
    end
    chk(state_code == 3'd3, "R10", "history write phase code", 64'(state_code), 3);
    drain();
    key_raw = 1'b0;

    // Capture 2: condition without key is ignored
    for (int n = 0; n < 99; n++) send_pre(mk(2, n), 1'b0);
    send_pre(mk(2, 99), 1'b1);
    chk(state_code == 3'd0, "R2", "condition in fill ignored", 64'(state_code), 0);
    for (int n = 100; n < 330; n++) send_pre(mk(2, n), 1'b0);
    step(1'b0, '0, 1'b1);
    chk(state_code == 3'd1, "R4", "condition without key ignored", 64'(state_code), 1);
    key_raw = 1'b1;
    idle(6);
    send_pre(mk(2, 330), 1'b1);
    chk(state_code == 3'd2, "R4", "trigger with key", 64'(state_code), 2);
    begin_post();
    for (int i = 0; i < SEG; i++) send_post(mk(2, 2000 + i));
    drain();
    key_raw = 1'b0;

    // Capture 3: key edge remembered from fill, exact fill, no wrap
    for (int n = 0; n < 100; n++) send_pre(mk(3, n), 1'b0);
    key_raw = 1'b1;
    idle(6);
    for (int n = 100; n < 199; n++) send_pre(mk(3, n), 1'b0);
    send_pre(mk(3, 199), 1'b1);
    chk(state_code == 3'd0, "R2", "condition in fill ignored with key", 64'(state_code), 0);
    for (int n = 200; n < SEG; n++) send_pre(mk(3, n), 1'b0);
    chk(state_code == 3'd1, "R2", "wait after exact fill", 64'(state_code), 1);
    step(1'b0, '0, 1'b1);
    chk(state_code == 3'd2, "R4", "key edge from fill used", 64'(state_code), 2);
    begin_post();
    for (int i = 0; i < SEG; i++) begin
      send_post(mk(3, 3000 + i));
      if (i % 4 == 1) idle(2);
    end
    drain();
    idle(2);

    chk(done_cnt == 3, "R8", "done strobes", 64'(done_cnt), 3);
    chk(exp_q.size() == 0, "R7", "all writes seen", 64'(exp_q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule